// File: doc/BRIEF.md
# Vectored Interrupt Peripheral Interface

This block is a bus peripheral that captures words arriving on an external port and asks a processor to service them through a vectored interrupt. When a word arrives, it is stored in an input data register and an interrupt request is raised. When the processor answers with an acknowledge, the peripheral places its own service-routine vector on the system read-data bus. The processor's handler can then fetch the stored word by reading the input register. That read is also what withdraws the request.

The handler writes its result back into an output data register, and that register is always visible on a dedicated output port. If a second word arrives before the first has been read, a sticky overrun flag records the loss and the newer word replaces the older one. The data bus is modelled as a read-data vector plus a drive-enable, so that a system-level mux or tristate stage can combine several such peripherals.

Top module: `vec_irq_periph`

## Requirements
- R1: Reset clears the input register, the output register, the request line `irq` and the `overrun` flag to 0.
- R2: A cycle with `arrive_valid` high stores `arrive_data` in the input register and raises `irq` from the next cycle. A later read at address 0x8000 returns that word.
- R3: While `irq_ack` is high, `bus_drive` is 1 and `bus_rdata` equals the VECTOR parameter (default 16). This takes precedence over any read in the same cycle.
- R4: A read at address 0x8000 with `irq_ack` low clears `irq` from the next cycle. If a word arrives in the same cycle as that read, `irq` stays high and the new word is stored.
- R5: `bus_drive` is 1 only during `irq_ack` or during a read at 0x8000 or 0x8001. In every other cycle `bus_drive` is 0 and `bus_rdata` is 0.
- R6: An arrival while `irq` is pending and not being cleared by a read in that cycle sets `overrun`. The flag then stays 1 until reset, and the newer word replaces the older one.
- R7: A write at address 0x8001 loads `bus_wdata` into the output register from the next cycle, visible on `out_data` and by a read at 0x8001. Writes to any other address leave both registers unchanged.
- R8: A read at 0x8000 made while `irq_ack` is high neither returns the input register nor clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive_valid | input | 1 | A new word is present on `arrive_data` |
| arrive_data | input | DATA_W | Incoming word |
| bus_addr | input | ADDR_W | System bus address |
| bus_wdata | input | DATA_W | System bus write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Read data or vector; 0 when not driving |
| bus_drive | output | 1 | Peripheral is driving the data bus |
| irq | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| out_data | output | DATA_W | Output data register contents |
| overrun | output | 1 | Sticky flag: a word was lost |

## Verification
The embedded properties check the following on every cycle:
- the request rises after each arrival;
- the request falls after a counted read of the input register;
- the request holds otherwise, including across reads made during acknowledge;
- the overrun flag is sticky;
- the vector is present whenever the acknowledge is high;
- the bus stays quiet without a strobe;
- the output register changes only on a write hit.

Only the bench scenarios can show the data paths end to end: the values actually returned by reads, the replacement of a word on overrun, the arrival-versus-read collision, and the fact that writes to foreign addresses are dropped.

// File: rtl/vip_pkg.sv
package vip_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_IN   = 2'd2,
        SEL_OUT  = 2'd3
    } rsel_e;
endpackage

// File: rtl/vip_decode.sv
module vip_decode
    import vip_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] IN_ADDR  = 16'h8000,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h8001
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              ack,
    output logic              take_in,
    output logic              wr_out,
    output rsel_e             sel
);
    logic hit_in;
    logic hit_out;

    always_comb begin
        hit_in  = (addr == IN_ADDR);
        hit_out = (addr == OUT_ADDR);
        // A read under acknowledge is not a register read (R8).
        take_in = rd && hit_in && !ack;
        wr_out  = wr && hit_out;
        if (ack)                 sel = SEL_VEC;
        else if (rd && hit_in)   sel = SEL_IN;
        else if (rd && hit_out)  sel = SEL_OUT;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/vip_capture.sv
module vip_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive_valid,
    input  logic [DATA_W-1:0] arrive_data,
    input  logic              take_in,
    output logic [DATA_W-1:0] in_data,
    output logic              irq,
    output logic              overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              req;
        logic              ovr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (take_in) cap_d.req = 1'b0;
        if (arrive_valid) begin
            cap_d.data = arrive_data;
            cap_d.req  = 1'b1;
            if (cap_q.req && !take_in) cap_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign in_data = cap_q.data;
    assign irq     = cap_q.req;
    assign overrun = cap_q.ovr;

    assert_irq_after_arrival_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arrive_valid |=> irq);
    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_in && !arrive_valid) |=> !irq);
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !take_in) |=> irq);
    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: rtl/vip_outreg.sv
module vip_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (wr_out) out_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_data = out_q;

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(out_data));
endmodule

// File: rtl/vip_busmux.sv
module vip_busmux
    import vip_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int VECTOR = 16
) (
    input  rsel_e             sel,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] out_data,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);
    localparam logic [DATA_W-1:0] VEC_VAL = DATA_W'(VECTOR);

    always_comb begin
        drive = 1'b1;
        unique case (sel)
            SEL_VEC: rdata = VEC_VAL;
            SEL_IN:  rdata = in_data;
            SEL_OUT: rdata = out_data;
            default: begin
                rdata = '0;
                drive = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vec_irq_periph.sv
module vec_irq_periph
    import vip_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] IN_ADDR  = 16'h8000,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h8001,
    parameter int VECTOR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive_valid,
    input  logic [DATA_W-1:0] arrive_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_drive,
    output logic              irq,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] out_data,
    output logic              overrun
);
    logic              take_in;
    logic              wr_out;
    rsel_e             sel;
    logic [DATA_W-1:0] in_data;

    vip_decode #(.ADDR_W(ADDR_W), .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR)) u_decode (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .ack(irq_ack),
        .take_in(take_in), .wr_out(wr_out), .sel(sel)
    );

    vip_capture #(.DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .arrive_valid(arrive_valid),
        .arrive_data(arrive_data), .take_in(take_in),
        .in_data(in_data), .irq(irq), .overrun(overrun)
    );

    vip_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk(clk), .rst_n(rst_n), .wr_out(wr_out),
        .wdata(bus_wdata), .out_data(out_data)
    );

    vip_busmux #(.DATA_W(DATA_W), .VECTOR(VECTOR)) u_busmux (
        .sel(sel), .in_data(in_data), .out_data(out_data),
        .rdata(bus_rdata), .drive(bus_drive)
    );

    assert_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (bus_drive && bus_rdata == DATA_W'(VECTOR)));
    assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && !bus_rd) |-> (!bus_drive && bus_rdata == '0));
endmodule

// File: tb/vec_irq_periph_test.sv
`timescale 1ns/1ps
module vec_irq_periph_test;
    localparam logic [15:0] A_IN  = 16'h8000;
    localparam logic [15:0] A_OUT = 16'h8001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arrive_valid = 1'b0;
    logic [7:0] arrive_data = '0;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0, irq_ack = 1'b0;
    logic [7:0] bus_rdata, out_data;
    logic bus_drive, irq, overrun;

    int total = 0, failed = 0;
    logic [8:0] expq[$];
    string tagq[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    vec_irq_periph uut (
        .clk(clk), .rst_n(rst_n), .arrive_valid(arrive_valid), .arrive_data(arrive_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_drive(bus_drive), .irq(irq), .irq_ack(irq_ack),
        .out_data(out_data), .overrun(overrun)
    );

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: each strobed cycle pops one expected {drive,data} item.
    always @(negedge clk) begin
        if (rst_n && (bus_rd || irq_ack)) begin
            if (expq.size() == 0) begin
                total++; failed++;
                $display("FAIL scoreboard: got %b_%h expected nothing", bus_drive, bus_rdata);
            end else begin
                automatic logic [8:0] e = expq.pop_front();
                automatic string t = tagq.pop_front();
                chk(t, {7'd0, bus_drive, bus_rdata}, {7'd0, e});
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic arrive(logic [7:0] d);
        arrive_valid = 1'b1; arrive_data = d; step(); arrive_valid = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [8:0] e, string t);
        expq.push_back(e); tagq.push_back(t);
        bus_addr = a; bus_rd = 1'b1; step(); bus_rd = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; step(); bus_wr = 1'b0;
    endtask

    task automatic ack(bit with_rd, string t);
        expq.push_back({1'b1, 8'd16}); tagq.push_back(t);
        irq_ack = 1'b1; bus_rd = with_rd; bus_addr = A_IN; step();
        irq_ack = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        step(); step(); rst_n = 1'b1; step();
        settle();
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 overrun", {15'd0, overrun}, 16'd0);
        chk("R1 out_data", {8'd0, out_data}, 16'd0);
        chk("R5 idle drive", {15'd0, bus_drive}, 16'd0);
        step();
        rd(A_IN, 9'h100, "R1 in reg read");
        rd(A_OUT, 9'h100, "R1 out reg read");

        arrive(8'hA5); settle();
        chk("R2 irq raised", {15'd0, irq}, 16'd1);
        step();
        ack(1'b0, "R3 vector");
        ack(1'b1, "R8 vector wins over read");
        settle();
        chk("R8 irq held", {15'd0, irq}, 16'd1);
        step();
        rd(A_IN, {1'b1, 8'hA5}, "R2 read data");
        settle();
        chk("R4 irq cleared", {15'd0, irq}, 16'd0);
        chk("R6 no overrun", {15'd0, overrun}, 16'd0);
        step();

        rd(16'h1234, 9'h000, "R5 foreign read");
        wr(A_OUT, 8'h3C); settle();
        chk("R7 out_data", {8'd0, out_data}, 16'h003C);
        step();
        rd(A_OUT, {1'b1, 8'h3C}, "R7 read back");
        wr(16'h8002, 8'h77);
        wr(A_IN, 8'h99); settle();
        chk("R7 foreign write", {8'd0, out_data}, 16'h003C);
        step();
        rd(A_IN, {1'b1, 8'hA5}, "R7 in reg untouched");

        arrive(8'h11); arrive(8'h22); settle();
        chk("R6 overrun set", {15'd0, overrun}, 16'd1);
        step();
        rd(A_IN, {1'b1, 8'h22}, "R6 newer word kept");
        settle();
        chk("R6 irq cleared", {15'd0, irq}, 16'd0);
        chk("R6 overrun sticky", {15'd0, overrun}, 16'd1);
        step();

        arrive(8'h44);
        expq.push_back({1'b1, 8'h44}); tagq.push_back("R4 collision read");
        bus_addr = A_IN; bus_rd = 1'b1; arrive_valid = 1'b1; arrive_data = 8'h55;
        step(); bus_rd = 1'b0; arrive_valid = 1'b0;
        settle();
        chk("R4 irq kept on collision", {15'd0, irq}, 16'd1);
        step();
        rd(A_IN, {1'b1, 8'h55}, "R4 new word stored");

        rst_n = 1'b0; step(); settle();
        chk("R1 overrun cleared", {15'd0, overrun}, 16'd0);
        chk("R1 out cleared", {8'd0, out_data}, 16'd0);
        rst_n = 1'b1; step();
        rd(A_IN, 9'h100, "R1 in cleared");
        settle();
        chk("R1 queue drained", 16'(expq.size()), 16'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule